// File: doc/BRIEF.md
# Programmable Burst Column Generator

This block produces the column address for every beat of one SDRAM read or write burst. A controller pulses `start` together with a start column, a burst length code, an ordering bit and a direction bit. From the next cycle the block presents one column per clock on `col_out` with `valid` high, and it raises `last` on the final beat. Bursts of 2, 4 or 8 beats stay inside the aligned block of that size that holds the start column, in either sequential or interleaved order. A full-page burst walks the whole 256-column row and keeps wrapping until it is stopped.

A burst ends early on `stop`, which covers a burst-stop or precharge decoded upstream. A fresh `start` cuts short the burst in progress and begins the new one. A low `cke` freezes the block for that edge. With the single-write mode bit set, every write burst is one beat long, while reads keep the programmed length.

Top module: `burst_colgen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `valid` and `last` are 0 and `col_out` is 0.
- R2: When `start` is sampled high with `cke` high, on the next cycle `valid` is 1 and `col_out` equals the sampled `start_col`.
- R3: The length code sets the beat count: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The codes 4, 5 and 6 give 1 beat. `valid` stays high for exactly that many cycles, `last` is 1 only on the final beat, and `valid` is 0 on the cycle after it.
- R4: With `ilv_mode`=0 and length L of 2, 4 or 8, beat i has the upper column bits of `start_col` and the low log2(L) bits equal to (start low bits + i) mod L.
- R5: With `ilv_mode`=1 and length L of 2, 4 or 8, beat i has the upper column bits of `start_col` and the low log2(L) bits equal to (start low bits) XOR i.
- R6: A full-page burst gives column (start_col + i) mod 256 at beat i in both ordering modes, so it wraps from 255 to 0. It never raises `last` and runs until stopped.
- R7: When `wr_single`=1 and `is_write`=1, the burst is 1 beat whatever the code. When `wr_single`=1 and `is_write`=0, or when `wr_single`=0, the programmed length applies.
- R8: `stop` sampled high with `cke` high and `start` low makes `valid` and `last` 0 on the next cycle.
- R9: A `start` during a burst abandons it. On the next cycle the new burst's first column appears, and its length and order follow the new inputs.
- R10: On an edge where `cke` is low, `col_out`, `valid` and `last` hold, and `start` and `stop` have no effect. When `cke` returns high, the sequence resumes with the next beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low freezes the block for that edge |
| start | input | 1 | Begin a burst with the inputs sampled on this edge |
| stop | input | 1 | Terminate the running burst |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst length code |
| ilv_mode | input | 1 | 0 = sequential, 1 = interleaved ordering |
| is_write | input | 1 | Burst is a write |
| wr_single | input | 1 | Single-write mode: writes are one beat |
| col_out | output | 8 | Column for the current beat |
| valid | output | 1 | A beat is being presented |
| last | output | 1 | Current beat is the final one |

## Verification
The bench starts bursts whose start columns lie in the middle or at the top of their aligned block. A design that carries the count into the upper bits leaves the block on the wrap, and one that mixes up XOR and add gives a wrong order in interleaved mode. A full-page run crosses column 255. A design that wraps it at some shorter length, or that raises `last`, fails there. Reserved codes and single-write combinations of direction and mode bit expose a wrong length decode. Stop, restart and `cke` freezes are applied mid-burst, with `start` and `stop` pulsed while frozen, so a design that advances or reacts while suspended shows a skipped or repeated column.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int COL_W  = 8;
  localparam int CODE_W = 3;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
  parameter int COL_W  = bcg_pkg::COL_W,
  parameter int CODE_W = bcg_pkg::CODE_W
) (
  input  logic [CODE_W-1:0] len_code,
  input  logic              is_write,
  input  logic              wr_single,
  output logic [COL_W-1:0]  mask,
  output logic              full
);
  localparam logic [CODE_W-1:0] CODE_FULL = {CODE_W{1'b1}};
  localparam int MAX_POW = 3;

  always_comb begin
    mask = '0;
    full = 1'b0;
    if (!(is_write && wr_single)) begin
      if (len_code == CODE_FULL) begin
        mask = '1;
        full = 1'b1;
      end else if (int'(len_code) <= MAX_POW) begin
        mask = COL_W'((32'd1 << len_code) - 32'd1);
      end
    end
  end
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
  parameter int COL_W = bcg_pkg::COL_W
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  input  logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] low;

  always_comb begin
    low = ilv ? (base ^ beat) : (base + beat);
    col = (base & ~mask) | (low & mask);
  end
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl #(
  parameter int COL_W = bcg_pkg::COL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_n,
  input  logic             full_n,
  input  logic             ilv_n,
  input  logic [COL_W-1:0] map_col,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] mask_q,
  output logic             ilv_q,
  output logic [COL_W-1:0] beat_nx,
  output logic [COL_W-1:0] col_q,
  output logic             active_q,
  output logic             last_q
);
  logic [COL_W-1:0] beat_q;
  logic             full_q;

  assign beat_nx = beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      mask_q   <= '0;
      ilv_q    <= 1'b0;
      full_q   <= 1'b0;
      beat_q   <= '0;
      col_q    <= '0;
      active_q <= 1'b0;
      last_q   <= 1'b0;
    end else if (cke) begin
      if (start) begin
        base_q   <= start_col;
        mask_q   <= mask_n;
        full_q   <= full_n;
        ilv_q    <= ilv_n & ~full_n;
        beat_q   <= '0;
        col_q    <= start_col;
        active_q <= 1'b1;
        last_q   <= (mask_n == '0);
      end else if (stop || last_q) begin
        active_q <= 1'b0;
        last_q   <= 1'b0;
      end else if (active_q) begin
        beat_q <= beat_nx;
        col_q  <= map_col;
        last_q <= !full_q && (beat_nx == mask_q);
      end
    end
  end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int COL_W  = bcg_pkg::COL_W,
  parameter int CODE_W = bcg_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              start,
  input  logic              stop,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] len_code,
  input  logic              ilv_mode,
  input  logic              is_write,
  input  logic              wr_single,
  output logic [COL_W-1:0]  col_out,
  output logic              valid,
  output logic              last
);
  logic [COL_W-1:0] mask_n, base_q, mask_q, beat_nx, map_col;
  logic             full_n, ilv_q;

  bcg_len_decode #(.COL_W(COL_W), .CODE_W(CODE_W)) dec_i (
    .len_code(len_code), .is_write(is_write), .wr_single(wr_single),
    .mask(mask_n), .full(full_n)
  );

  bcg_col_map #(.COL_W(COL_W)) map_i (
    .base(base_q), .mask(mask_q), .ilv(ilv_q), .beat(beat_nx), .col(map_col)
  );

  bcg_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk(clk), .rst(rst), .cke(cke), .start(start), .stop(stop),
    .start_col(start_col), .mask_n(mask_n), .full_n(full_n), .ilv_n(ilv_mode),
    .map_col(map_col), .base_q(base_q), .mask_q(mask_q), .ilv_q(ilv_q),
    .beat_nx(beat_nx), .col_q(col_out), .active_q(valid), .last_q(last)
  );
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
  parameter int COL_W  = bcg_pkg::COL_W,
  parameter int CODE_W = bcg_pkg::CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              start,
  input logic              stop,
  input logic [COL_W-1:0]  start_col,
  input logic [CODE_W-1:0] len_code,
  input logic              is_write,
  input logic              wr_single,
  input logic [COL_W-1:0]  col_out,
  input logic              valid,
  input logic              last
);
  AST_START_COL: assert property (@(posedge clk) disable iff (rst)
    (cke && start) |=> (valid && col_out == $past(start_col))); // R2
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
    last |-> valid); // R3
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (cke && last && !start) |=> !valid); // R3
  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (rst)
    (cke && start && len_code == {CODE_W{1'b1}} && !(is_write && wr_single)) |=> !last); // R6
  AST_SINGLE_WR: assert property (@(posedge clk) disable iff (rst)
    (cke && start && is_write && wr_single) |=> last); // R7
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (cke && stop && !start) |=> (!valid && !last)); // R8
  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(col_out) && $stable(valid) && $stable(last))); // R10
endmodule

bind burst_colgen bcg_chk #(.COL_W(COL_W), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .cke(cke), .start(start), .stop(stop),
  .start_col(start_col), .len_code(len_code), .is_write(is_write),
  .wr_single(wr_single), .col_out(col_out), .valid(valid), .last(last)
);

// File: tb/burst_colgen_tb_top.sv
module burst_colgen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] start_col = 8'h00;
  logic [2:0] len_code = 3'd0;
  logic       ilv_mode = 1'b0;
  logic       is_write = 1'b0;
  logic       wr_single = 1'b0;
  logic [7:0] col_out;
  logic       valid, last;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_colgen dut_i (
    .clk(clk), .rst(rst), .cke(cke), .start(start), .stop(stop),
    .start_col(start_col), .len_code(len_code), .ilv_mode(ilv_mode),
    .is_write(is_write), .wr_single(wr_single),
    .col_out(col_out), .valid(valid), .last(last)
  );

  // fields: start column, code, ilv, write, single-write, expected beats
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {8'h35, 3'd2, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 mid-block wrap
    {8'h35, 3'd2, 1'b1, 1'b0, 1'b0, 4'd4},  // R5
    {8'h3E, 3'd3, 1'b0, 1'b0, 1'b0, 4'd8},  // R4
    {8'h3E, 3'd3, 1'b1, 1'b0, 1'b0, 4'd8},  // R5
    {8'h81, 3'd1, 1'b0, 1'b0, 1'b0, 4'd2},  // R3 R4
    {8'hFF, 3'd1, 1'b1, 1'b0, 1'b0, 4'd2},  // R5
    {8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 4'd1},  // R3
    {8'h22, 3'd5, 1'b0, 1'b0, 1'b0, 4'd1},  // R3 reserved
    {8'h47, 3'd3, 1'b0, 1'b1, 1'b1, 4'd1},  // R7 single write
    {8'h47, 3'd3, 1'b0, 1'b0, 1'b1, 4'd8},  // R7 read keeps length
    {8'h47, 3'd2, 1'b0, 1'b1, 1'b0, 4'd4}   // R7 mode off
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int sc, input int n, input bit ilv, input int i);
    int lo = sc % n;
    int blk = sc - lo;
    if (ilv && n != 256) return (blk + (lo ^ i)) & 255;
    return (blk + ((lo + i) % n)) & 255;
  endfunction

  task automatic begin_burst(input logic [7:0] c, input logic [2:0] code,
                             input logic il, input logic w, input logic s1);
    start_col = c; len_code = code; ilv_mode = il; is_write = w; wr_single = s1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", valid, 0);
    chk("R1 last in reset", last, 0);
    chk("R1 col in reset", col_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", valid, 0);

    for (int v = 0; v < NV; v++) begin
      logic [17:0] e = VEC[v];
      int n = int'(e[3:0]);
      int ln = (n == 1) ? 1 : int'(32'd1 << e[9:7]);
      begin_burst(e[17:10], e[9:7], e[6], e[5], e[4]);
      for (int i = 0; i < n; i++) begin
        chk("R2 R3 valid", valid, 1);
        chk("R4 R5 col", col_out, exp_col(int'(e[17:10]), ln, e[6], i));
        chk("R3 last", last, (i == n - 1) ? 1 : 0);
        @(negedge clk);
      end
      chk("R3 R7 ended", valid, 0);
      @(negedge clk);
    end

    // R6 full page, interleave bit set, crosses 255
    begin_burst(8'hFD, 3'd7, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 260; i++) begin
      chk("R6 valid", valid, 1);
      chk("R6 col", col_out, (253 + i) % 256);
      chk("R6 no last", last, 0);
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stop full page", valid, 0);

    // R8 stop mid burst
    begin_burst(8'h60, 3'd3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 beat1", col_out, 8'h61);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 valid low", valid, 0);
    chk("R8 last low", last, 0);

    // R9 restart during burst
    begin_burst(8'h10, 3'd3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 old beat1", col_out, 8'h11);
    begin_burst(8'h50, 3'd1, 1'b0, 1'b0, 1'b0);
    chk("R9 new first", col_out, 8'h50);
    chk("R9 new first last", last, 0);
    @(negedge clk);
    chk("R9 new second", col_out, 8'h51);
    chk("R9 new second last", last, 1);
    @(negedge clk);
    chk("R9 new ends", valid, 0);

    // R10 clock enable freeze with start/stop pulsed
    begin_burst(8'h2B, 3'd3, 1'b0, 1'b0, 1'b0);
    chk("R10 beat0", col_out, 8'h2B);
    @(negedge clk);
    chk("R10 beat1", col_out, 8'h2C);
    cke = 1'b0; start = 1'b1; stop = 1'b1; start_col = 8'h99;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 hold col", col_out, 8'h2C);
      chk("R10 hold valid", valid, 1);
    end
    cke = 1'b1; start = 1'b0; stop = 1'b0;
    for (int i = 2; i < 8; i++) begin
      @(negedge clk);
      chk("R10 resume col", col_out, exp_col(8'h2B, 8, 1'b0, i));
      chk("R10 resume last", last, (i == 7) ? 1 : 0);
    end
    @(negedge clk);
    chk("R10 resume end", valid, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule